// File: doc/BRIEF.md
# Fixed-Frequency Peak-Current-Mode Switch Controller

This block produces the on/off command for the power switch of a boost converter. It divides the system clock into switching periods of fixed length. At the start of each period it turns the switch on. It turns the switch off again when one of the following happens:

- the sensed-current code plus a slope-compensation ramp rises above the demand code from the error amplifier;
- the sensed current alone goes above a current-limit code;
- the maximum on-time is reached.

Once the switch is off, it stays off until the next period starts. An overvoltage flag holds the switch off while it is high. This hold is not latched: normal switching returns at the next period start after the flag clears. A per-period flag reports whether the current limit ended the on-time.

The analog loop is modelled by codes at the block's inputs. The sensed switch current, the demand level and the current-limit threshold all arrive as unsigned codes. The slope ramp is generated inside the block from a programmable per-clock increment. The default period of 100 clocks at 120 MHz gives a 1.2 MHz switching rate. The default maximum duty setting of 94 % allows 94 on-cycles in each period.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: While `en_i` is high, `start_o` is high for exactly one cycle in every `PERIOD_CYC` cycles. Counting period cycles k = 0 .. PERIOD_CYC-1, `start_o` is high in cycle k = 0. The first period begins in the cycle in which `en_i` is first seen high.
- R2: In cycle k = 0 the switch is on unless one of the turn-off conditions (R3, R5, R7) holds in that cycle. The switch can go from off to on only in a cycle where `start_o` is high.
- R3: The slope ramp in cycle k is min(k × `slope_inc_i`, 2^RAMP_W − 1). The switch is off in any cycle where `isense_i` + ramp > `demand_i`. The comparison is strict: when the sum equals `demand_i`, the switch stays on.
- R4: After the switch goes off, it stays off for the rest of that period, even if the turn-off condition goes away.
- R5: In any cycle where `isense_i` > `ilim_i` (strictly greater), the switch is off in that same cycle and stays off until the next period.
- R6: The switch is off in every cycle k ≥ MAX_ON_CYC, where MAX_ON_CYC = PERIOD_CYC × MAX_DUTY_PCT / 100 (integer division).
- R7: While `ovp_i` is high, the switch is off. When `ovp_i` clears part-way through a period, the switch stays off for the rest of that period. Switching restarts at the next period start after the flag is low.
- R8: While `en_i` is low:
  - `sw_on_o` and `start_o` are low;
  - the period counter and the ramp are held at zero;
  - `ilim_flag_o` is cleared on the next clock.
- R9: `ilim_flag_o` goes high in the cycle after the current limit (R5) turns off a switch that would otherwise have been on. It stays high through cycle k = 0 of the next period. It is then reloaded, so it shows 0 from cycle 1 unless the limit trips again in cycle 0.
- R10: While `rst_ni` is low, and with `en_i` low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low the switch is off and the period counter is held in reset |
| ovp_i | input | 1 | Overvoltage flag; holds the switch off (not latched) |
| isense_i | input | CODE_W | Sensed switch-current code |
| demand_i | input | CODE_W | Error-amplifier demand code |
| ilim_i | input | CODE_W | Current-limit threshold code |
| slope_inc_i | input | INC_W | Slope ramp increment per clock |
| sw_on_o | output | 1 | Power switch on command |
| start_o | output | 1 | Period start strobe |
| ilim_flag_o | output | 1 | Current limit ended the on-time in the most recent period |

## Verification
`sw_on_o` and `start_o` respond in the same cycle as the inputs. A change to `isense_i`, `demand_i`, `ilim_i` or `ovp_i` shows up on `sw_on_o` in that cycle. The cycle after, it also shows up through the on-state register. The ramp grows by one increment at each edge. `ilim_flag_o` is registered, so it changes one cycle after the trip.

The bench drives inputs on the falling edge and samples 1 ns later. Each sampled cycle is compared with a per-cycle model indexed by period cycle k. That model works out the on-state and the flag from the requirements. It compares against the ramp min(k·inc, 31) and carries forward the "stayed on so far" and "limit fired earlier" terms.

A sweep covers 64 combinations of current, demand and increment. Directed periods cover:
- ties at the limit and at the demand;
- a current step partway through a period;
- overvoltage windows inside a period and across a period start;
- an enable drop.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;

  function automatic int unsigned max_on_cycles(input int unsigned period, input int unsigned pct);
    return (period * pct) / 100;
  endfunction

  function automatic int unsigned sum_width(input int unsigned a, input int unsigned b);
    return ((a > b) ? a : b) + 1;
  endfunction

endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
  parameter int unsigned PERIOD_CYC = 100,
  parameter int unsigned MAX_ON_CYC = 94,
  parameter int unsigned CNT_W      = $clog2(PERIOD_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             last_o,
  output logic             win_o
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign last_o  = (cnt_q == LAST_C);
  assign start_o = en_i && (cnt_q == '0);

  generate
    if (MAX_ON_CYC >= PERIOD_CYC) begin : g_win_full
      assign win_o = 1'b1;
    end else begin : g_win_cut
      localparam logic [CNT_W:0] MAX_ON_C = (CNT_W+1)'(MAX_ON_CYC);
      assign win_o = ({1'b0, cnt_q} < MAX_ON_C);
    end
  endgenerate

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < (CNT_W+1)'(PERIOD_CYC)));

  assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_o) |=> (cnt_q == '0));

endmodule

// File: rtl/pcm_slope_ramp.sv
module pcm_slope_ramp #(
  parameter int unsigned INC_W  = 6,
  parameter int unsigned RAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [RAMP_W-1:0] ramp_o
);

  logic [RAMP_W-1:0] ramp_q;
  logic [RAMP_W:0]   sum;

  assign sum = {1'b0, ramp_q} + {{(RAMP_W+1-INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ramp_q <= '0;
    else if (clr_i)      ramp_q <= '0;
    else if (sum[RAMP_W]) ramp_q <= '1;
    else                 ramp_q <= sum[RAMP_W-1:0];
  end

  assign ramp_o = ramp_q;

  assert_ramp_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (ramp_q >= $past(ramp_q)));

endmodule

// File: rtl/pcm_switch_latch.sv
module pcm_switch_latch
  import pcm_pwm_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned RAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              win_i,
  input  logic              ovp_i,
  input  logic [CODE_W-1:0] isense_i,
  input  logic [CODE_W-1:0] demand_i,
  input  logic [CODE_W-1:0] ilim_i,
  input  logic [RAMP_W-1:0] ramp_i,
  output logic              sw_o,
  output logic              ilim_flag_o
);

  localparam int unsigned SUM_W = sum_width(CODE_W, RAMP_W);

  logic [SUM_W-1:0] sense_sum;
  logic             pwm_trip, lim_trip, armed;
  logic             on_q, flag_q;

  assign sense_sum = SUM_W'(isense_i) + SUM_W'(ramp_i);
  assign pwm_trip  = sense_sum > SUM_W'(demand_i);
  assign lim_trip  = isense_i > ilim_i;

  // set by period start, held by on_q, cut by window, ovp, comparators
  assign armed = (start_i | on_q) & en_i & win_i & ~ovp_i;
  assign sw_o  = armed & ~pwm_trip & ~lim_trip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (!en_i) begin
      on_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      on_q   <= sw_o;
      flag_q <= (start_i ? 1'b0 : flag_q) | (armed & lim_trip);
    end
  end

  assign ilim_flag_o = flag_q;

  assert_pwm_hold_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_trip) |=> (!sw_o || start_i));

  assert_lim_hold_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lim_trip) |=> (!sw_o || start_i));

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && armed && lim_trip) |=> ilim_flag_o);

endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
  import pcm_pwm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 100,
  parameter int unsigned MAX_DUTY_PCT = 94,
  parameter int unsigned CODE_W       = 10,
  parameter int unsigned RAMP_W       = 10,
  parameter int unsigned INC_W        = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ovp_i,
  input  logic [CODE_W-1:0] isense_i,
  input  logic [CODE_W-1:0] demand_i,
  input  logic [CODE_W-1:0] ilim_i,
  input  logic [INC_W-1:0]  slope_inc_i,
  output logic              sw_on_o,
  output logic              start_o,
  output logic              ilim_flag_o
);

  localparam int unsigned MAX_ON_CYC = max_on_cycles(PERIOD_CYC, MAX_DUTY_PCT);
  localparam int unsigned CNT_W      = $clog2(PERIOD_CYC);

  logic [CNT_W-1:0]  cnt;
  logic              start, last, win;
  logic [RAMP_W-1:0] ramp;

  pcm_period_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .MAX_ON_CYC (MAX_ON_CYC),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .cnt_o   (cnt),
    .start_o (start),
    .last_o  (last),
    .win_o   (win)
  );

  pcm_slope_ramp #(
    .INC_W  (INC_W),
    .RAMP_W (RAMP_W)
  ) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i || last),
    .inc_i  (slope_inc_i),
    .ramp_o (ramp)
  );

  pcm_switch_latch #(
    .CODE_W (CODE_W),
    .RAMP_W (RAMP_W)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .start_i     (start),
    .win_i       (win),
    .ovp_i       (ovp_i),
    .isense_i    (isense_i),
    .demand_i    (demand_i),
    .ilim_i      (ilim_i),
    .ramp_i      (ramp),
    .sw_o        (sw_on_o),
    .ilim_flag_o (ilim_flag_o)
  );

  assign start_o = start;

  assert_ramp_zero_at_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (ramp == '0));

  assert_turn_on_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_on_o) |-> start_o);

  assert_max_duty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_o |-> ({1'b0, cnt} < (CNT_W+1)'(MAX_ON_CYC)));

  assert_ovp_no_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovp_i) && !start_o) |-> !sw_on_o);

  assert_disable_resets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == '0 && ramp == '0));

endmodule

// File: tb/pcm_pwm_ctrl_bench.sv
module pcm_pwm_ctrl_bench;

  localparam int P      = 20;
  localparam int PCT    = 90;
  localparam int MAXON  = (P * PCT) / 100;
  localparam int CW     = 6;
  localparam int RW     = 5;
  localparam int IW     = 3;
  localparam int RMAX   = (1 << RW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          ovp_i = 1'b0;
  logic [CW-1:0] isense_i = '0;
  logic [CW-1:0] demand_i = '0;
  logic [CW-1:0] ilim_i = '0;
  logic [IW-1:0] slope_inc_i = '0;
  logic          sw_on_o, start_o, ilim_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit prev_flag = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pcm_pwm_ctrl #(
    .PERIOD_CYC   (P),
    .MAX_DUTY_PCT (PCT),
    .CODE_W       (CW),
    .RAMP_W       (RW),
    .INC_W        (IW)
  ) u_pcm_pwm_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ovp_i       (ovp_i),
    .isense_i    (isense_i),
    .demand_i    (demand_i),
    .ilim_i      (ilim_i),
    .slope_inc_i (slope_inc_i),
    .sw_on_o     (sw_on_o),
    .start_o     (start_o),
    .ilim_flag_o (ilim_flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // One period with inputs stepping from lo to hi at cycle step, ovp high in [oa, ob).
  task automatic run_period(input int lo, input int hi, input int step, input int dem,
                            input int lim, input int inc, input int oa, input int ob,
                            input string req);
    bit alive = 1'b0;
    bit acc = 1'b0;
    for (int k = 0; k < P; k++) begin
      int isv, rmp;
      bit ov, ptrip, ltrip, cand, on, fexp;
      @(negedge clk_i);
      isv = (k >= step) ? hi : lo;
      ov  = (k >= oa) && (k < ob);
      en_i = 1'b1;
      ovp_i = ov;
      isense_i = CW'(isv);
      demand_i = CW'(dem);
      ilim_i = CW'(lim);
      slope_inc_i = IW'(inc);
      #1;
      rmp   = (k * inc > RMAX) ? RMAX : k * inc;
      ptrip = (isv + rmp) > dem;
      ltrip = isv > lim;
      cand  = ((k == 0) || alive) && (k < MAXON) && !ov;
      on    = cand && !ptrip && !ltrip;
      fexp  = (k == 0) ? prev_flag : acc;
      chk({req, " R1 start"}, int'(start_o), int'(k == 0));
      chk({req, " sw"}, int'(sw_on_o), int'(on));
      chk({req, " R9 flag"}, int'(ilim_flag_o), int'(fexp));
      acc   = acc | (cand && ltrip);
      alive = on;
    end
    prev_flag = acc;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R10 reset sw", int'(sw_on_o), 0);
    chk("R10 reset start", int'(start_o), 0);
    chk("R10 reset flag", int'(ilim_flag_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk("R8 idle sw", int'(sw_on_o), 0);
    chk("R8 idle start", int'(start_o), 0);

    // R3 R4 R6 sweep: constant inputs per period, no limit, no ovp
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          run_period(a * 13, a * 13, 0, b * 21, 63, (1 << c) - 1, P, P, "R3/R4/R6 sweep");

    // R3 tie: sum equal to demand keeps switch on
    run_period(20, 20, 0, 30, 63, 1, P, P, "R3 tie");
    // R6: never tripped, bounded by max on-time
    run_period(0, 0, 0, 63, 63, 0, P, P, "R6 max on");
    // R5: equal to limit does not trip; one above trips at cycle 0
    run_period(10, 10, 0, 63, 10, 1, P, P, "R5 equal");
    run_period(10, 10, 0, 63, 9, 1, P, P, "R5 over");
    // R9: flag seen in k=0 of next period, then reloaded
    run_period(5, 5, 0, 63, 63, 1, P, P, "R9 clear");
    // R5 R9: current step mid-period crosses the limit
    run_period(5, 40, 6, 63, 30, 1, P, P, "R5 mid step");
    // R4: comparator trip then current drops; stays off
    run_period(40, 0, 4, 45, 63, 1, P, P, "R4 stay off");
    // R7: ovp window inside period, then across a start
    run_period(5, 5, 0, 63, 63, 1, 4, 9, "R7 mid ovp");
    run_period(5, 5, 0, 63, 63, 1, 0, 3, "R7 ovp at start");
    run_period(5, 5, 0, 63, 63, 1, P, P, "R7 resume");
    // R8: limit trip, then drop enable mid period
    run_period(50, 50, 0, 63, 30, 1, P, P, "R8 pre");
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      isense_i = '0;
      ilim_i = '1;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      en_i = 1'b0;
      #1;
      chk("R8 disabled sw", int'(sw_on_o), 0);
      chk("R8 disabled start", int'(start_o), 0);
      if (i > 0) chk("R8 disabled flag", int'(ilim_flag_o), 0);
    end
    prev_flag = 1'b0;
    run_period(5, 5, 0, 63, 63, 2, P, P, "R8 restart");
    run_period(0, 0, 0, 20, 63, 7, P, P, "R3 saturate");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule